// File: doc/BRIEF.md
# Keypad Port Interrupt Gate

This block turns eight keypad-style input pins into one interrupt request. Each pin is synchronized and compared against its own active condition. The lower four pins are active when they read low. The upper four pins are active when they equal a programmable polarity bit. A per-pin enable then qualifies each active pin, and all qualified pins are combined into a single condition.

The condition drives an interrupt flag in one of two modes. In level mode the flag tracks the condition, so a source that stays active raises the request again after service. In edge mode the flag captures a rising edge of the combined condition and holds it until the interrupt controller acknowledges it. Software can set or clear the flag directly, with the same effect as a hardware event.

Top module: `kpd_irq_gate`

## Requirements
- R1: Pin n, for n from 0 to 3, is active when pin_i[n] is 0.
- R2: Pin n, for n from 4 to 7, is active when pin_i[n] equals lvl_sel_i[n-4].
- R3: An active pin contributes to the request only when gate_en_i[n] is 1. With gate_en_i at 0 the request never rises from pin activity.
- R4: The combined condition is the OR of all enabled active pins.
- R5: With edge_mode_i at 0, irq_o equals the combined condition of the previous cycle, ORed with sw_set_i of the previous cycle. ack_i and sw_clr_i cannot hold it low while the condition is active.
- R6: With edge_mode_i at 1, irq_o is set by a 0-to-1 change of the combined condition and then holds its value. A condition that stays active does not set it again.
- R7: With edge_mode_i at 1, an ack_i or sw_clr_i pulse clears irq_o at the next edge when no new event or software set arrives in the same cycle.
- R8: With edge_mode_i at 1, a condition rising edge in the same cycle as ack_i leaves irq_o set.
- R9: A sw_set_i pulse sets irq_o at the next edge in either mode. sw_set_i takes priority over sw_clr_i.
- R10: While rst_ni is low, irq_o is 0 whatever the pins show.
- R11: A pin change first shows on irq_o after the third rising clock edge. Two edges come from synchronization and one from the flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pin_i | input | 8 | Raw pin levels, asynchronous |
| gate_en_i | input | 8 | Per-pin enable |
| lvl_sel_i | input | 4 | Active polarity for pins 4 to 7 |
| edge_mode_i | input | 1 | 1 selects edge capture, 0 selects level |
| ack_i | input | 1 | Interrupt taken strobe |
| sw_set_i | input | 1 | Software set of the flag |
| sw_clr_i | input | 1 | Software clear of the flag |
| irq_o | output | 1 | Interrupt request flag |

## Verification
The match logic is swept in level mode over all 256 pin values for each of the 16 polarity settings, with every pin enabled. This separates the fixed-low rule of the lower pins from the polarity rule of the upper ones. A second sweep runs all 256 enable masks against eight pin patterns, including complementary and alternating ones, which exposes a wrong mask bit or a missing OR term. Directed sequences then set pin, acknowledge and software strobes at chosen edges to tell edge capture from level tracking. The same sequences check the acknowledge-versus-event collision and the three-edge latency.

// File: rtl/kpd_irq_pkg.sv
package kpd_irq_pkg;
  localparam int unsigned KPD_PINS  = 8;
  localparam int unsigned KPD_LOW   = 4;
  localparam int unsigned KPD_SYNC  = 2;

  typedef enum logic {
    TRIG_LEVEL = 1'b0,
    TRIG_EDGE  = 1'b1
  } trig_mode_e;
endpackage

// File: rtl/kpd_sync.sv
module kpd_sync #(
  parameter int unsigned W     = 8,
  parameter int unsigned DEPTH = 2,
  parameter logic        RVAL  = 1'b1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stg_q[0] <= {W{RVAL}};
    else         stg_q[0] <= d_i;
  end

  for (genvar s = 1; s < DEPTH; s++) begin : g_stg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stg_q[s] <= {W{RVAL}};
      else         stg_q[s] <= stg_q[s-1];
    end
  end

  assign q_o = stg_q[DEPTH-1];
endmodule

// File: rtl/kpd_match.sv
module kpd_match #(
  parameter int unsigned PINS     = 8,
  parameter int unsigned LOW_PINS = 4,
  localparam int unsigned HI_PINS = PINS - LOW_PINS
) (
  input  logic [PINS-1:0]    pin_i,
  input  logic [PINS-1:0]    gate_en_i,
  input  logic [HI_PINS-1:0] lvl_sel_i,
  output logic               any_o
);
  logic [PINS-1:0] hit;

  for (genvar i = 0; i < PINS; i++) begin : g_pin
    if (i < LOW_PINS) begin : g_low
      assign hit[i] = ~pin_i[i];
    end else begin : g_pol
      assign hit[i] = ~(pin_i[i] ^ lvl_sel_i[i-LOW_PINS]);
    end
  end

  assign any_o = |(hit & gate_en_i);
endmodule

// File: rtl/kpd_flag.sv
module kpd_flag
  import kpd_irq_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       cond_i,
  input  trig_mode_e mode_i,
  input  logic       ack_i,
  input  logic       set_i,
  input  logic       clr_i,
  output logic       flag_o
);
  logic cond_q, flag_q, flag_d, rise;

  assign rise = cond_i & ~cond_q;

  always_comb begin
    unique case (mode_i)
      TRIG_EDGE: flag_d = rise | set_i | (flag_q & ~ack_i & ~clr_i);
      default:   flag_d = cond_i | set_i;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cond_q <= 1'b0;
      flag_q <= 1'b0;
    end else begin
      cond_q <= cond_i;
      flag_q <= flag_d;
    end
  end

  assign flag_o = flag_q;
endmodule

// File: rtl/kpd_irq_gate.sv
module kpd_irq_gate
  import kpd_irq_pkg::*;
#(
  parameter int unsigned PINS       = KPD_PINS,
  parameter int unsigned LOW_PINS   = KPD_LOW,
  parameter int unsigned SYNC_DEPTH = KPD_SYNC,
  localparam int unsigned HI_PINS   = PINS - LOW_PINS
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [PINS-1:0]    pin_i,
  input  logic [PINS-1:0]    gate_en_i,
  input  logic [HI_PINS-1:0] lvl_sel_i,
  input  logic               edge_mode_i,
  input  logic               ack_i,
  input  logic               sw_set_i,
  input  logic               sw_clr_i,
  output logic               irq_o
);
  logic [PINS-1:0] pin_s;
  logic            any_hit;
  trig_mode_e      mode;

  assign mode = trig_mode_e'(edge_mode_i);

  // idle high so the low-active pins stay quiet out of reset
  kpd_sync #(.W(PINS), .DEPTH(SYNC_DEPTH), .RVAL(1'b1)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pin_i),
    .q_o   (pin_s)
  );

  kpd_match #(.PINS(PINS), .LOW_PINS(LOW_PINS)) u_match (
    .pin_i    (pin_s),
    .gate_en_i(gate_en_i),
    .lvl_sel_i(lvl_sel_i),
    .any_o    (any_hit)
  );

  kpd_flag u_flag (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .cond_i(any_hit),
    .mode_i(mode),
    .ack_i (ack_i),
    .set_i (sw_set_i),
    .clr_i (sw_clr_i),
    .flag_o(irq_o)
  );
endmodule

// File: rtl/kpd_irq_gate_chk.sv
module kpd_irq_gate_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic edge_mode_i,
  input logic ack_i,
  input logic sw_set_i,
  input logic sw_clr_i,
  input logic cond_i,
  input logic irq_o
);
  logic cond_prev;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cond_prev <= 1'b0;
    else         cond_prev <= cond_i;
  end

  // R5
  level_track_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!edge_mode_i && !sw_set_i) |=> (irq_o == $past(cond_i)));

  // R6
  edge_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (edge_mode_i && irq_o && !ack_i && !sw_clr_i) |=> irq_o);

  // R7
  ack_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (edge_mode_i && (ack_i || sw_clr_i) && !sw_set_i && !(cond_i && !cond_prev))
    |=> !irq_o);

  // R8
  event_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (edge_mode_i && cond_i && !cond_prev) |=> irq_o);

  // R9
  sw_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sw_set_i |=> irq_o);

  // R10
  always_comb begin
    if (!rst_ni) reset_low_chk: assert (!irq_o);
  end
endmodule

bind kpd_irq_gate kpd_irq_gate_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .edge_mode_i(edge_mode_i),
  .ack_i      (ack_i),
  .sw_set_i   (sw_set_i),
  .sw_clr_i   (sw_clr_i),
  .cond_i     (any_hit),
  .irq_o      (irq_o)
);

// File: tb/sim_kpd_irq_gate.sv
module sim_kpd_irq_gate;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] pin = 8'hFF;
  logic [7:0] gate = 8'h00;
  logic [3:0] lvl = 4'h0;
  logic       mode = 1'b0;
  logic       ack = 1'b0;
  logic       sset = 1'b0;
  logic       sclr = 1'b0;
  logic       irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  kpd_irq_gate u0 (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .pin_i      (pin),
    .gate_en_i  (gate),
    .lvl_sel_i  (lvl),
    .edge_mode_i(mode),
    .ack_i      (ack),
    .sw_set_i   (sset),
    .sw_clr_i   (sclr),
    .irq_o      (irq)
  );

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input logic got, input logic exp, input string req);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %0b expected %0b", req, got, exp);
    end
  endtask

  function automatic logic model(input logic [7:0] p, input logic [7:0] g,
                                 input logic [3:0] l);
    logic r = 1'b0;
    for (int i = 0; i < 4; i++) if (g[i] && !p[i]) r = 1'b1;
    for (int i = 4; i < 8; i++) if (g[i] && (p[i] == l[i-4])) r = 1'b1;
    return r;
  endfunction

  function automatic logic [7:0] pat(input int k);
    case (k)
      0: return 8'h00;
      1: return 8'hFF;
      2: return 8'h0F;
      3: return 8'hF0;
      4: return 8'h55;
      5: return 8'hAA;
      6: return 8'h96;
      default: return 8'h69;
    endcase
  endfunction

  initial begin
    #(200000 * 5);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog got timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    // R10: matching pins during reset
    gate = 8'hFF; pin = 8'h00;
    tick(3);
    chk(irq, 1'b0, "R10 reset");
    pin = 8'hFF; gate = 8'h00;
    rst_n = 1'b1;
    tick(3);
    chk(irq, 1'b0, "R10 after reset");

    // R1 R2 R4: level mode, all pins enabled, full sweep
    mode = 1'b0; gate = 8'hFF;
    for (int l = 0; l < 16; l++) begin
      for (int p = 0; p < 256; p++) begin
        lvl = 4'(l); pin = 8'(p);
        tick(3);
        chk(irq, model(8'(p), 8'hFF, 4'(l)), "R1/R2/R4 sweep");
      end
    end

    // R3 R4: every enable mask against fixed patterns
    lvl = 4'b0110;
    for (int g = 0; g < 256; g++) begin
      for (int k = 0; k < 8; k++) begin
        gate = 8'(g); pin = pat(k);
        tick(3);
        chk(irq, model(pat(k), 8'(g), 4'b0110), "R3/R4 mask");
      end
    end

    // R11: latency in level mode
    gate = 8'h01; pin = 8'hFF; tick(4);
    chk(irq, 1'b0, "R11 idle");
    pin = 8'hFE;
    tick(2);
    chk(irq, 1'b0, "R11 two edges");
    tick(1);
    chk(irq, 1'b1, "R11 three edges");

    // R5: ack and clear cannot hold level request low
    ack = 1'b1; sclr = 1'b1; tick(1);
    ack = 1'b0; sclr = 1'b0;
    chk(irq, 1'b1, "R5 ack in level mode");
    tick(2);
    chk(irq, 1'b1, "R5 reasserts");
    pin = 8'hFF; tick(3);
    chk(irq, 1'b0, "R5 follows release");

    // R9: software set in level mode lasts one cycle when condition idle
    sset = 1'b1; tick(1); sset = 1'b0;
    chk(irq, 1'b1, "R9 set level");
    tick(1);
    chk(irq, 1'b0, "R5 set drops");

    // R6: edge capture and hold
    mode = 1'b1; tick(3);
    chk(irq, 1'b0, "R6 edge idle");
    pin = 8'hFE;
    tick(2);
    chk(irq, 1'b0, "R11 edge two edges");
    tick(1);
    chk(irq, 1'b1, "R6 edge set");
    tick(5);
    chk(irq, 1'b1, "R6 hold");

    // R7: ack clears, steady condition does not re-set
    ack = 1'b1; tick(1); ack = 1'b0;
    chk(irq, 1'b0, "R7 ack clear");
    tick(5);
    chk(irq, 1'b0, "R6 no retrigger");
    pin = 8'hFF; tick(4);
    chk(irq, 1'b0, "R6 release");

    // R9: set, clear, and set over clear in edge mode
    sset = 1'b1; tick(1); sset = 1'b0;
    chk(irq, 1'b1, "R9 set edge");
    tick(3);
    chk(irq, 1'b1, "R6 software hold");
    sclr = 1'b1; tick(1); sclr = 1'b0;
    chk(irq, 1'b0, "R7 sw clear");
    sset = 1'b1; sclr = 1'b1; tick(1); sset = 1'b0; sclr = 1'b0;
    chk(irq, 1'b1, "R9 set beats clear");

    // R8: event and ack in same cycle
    pin = 8'hFE;
    repeat (2) @(posedge clk);
    @(negedge clk);
    ack = 1'b1;
    tick(1);
    ack = 1'b0;
    chk(irq, 1'b1, "R8 event wins");
    ack = 1'b1; tick(1); ack = 1'b0;
    chk(irq, 1'b0, "R7 ack after collision");

    // R2: upper pin polarity in edge mode
    pin = 8'hFF; gate = 8'h80; lvl = 4'b0000; tick(4);
    chk(irq, 1'b0, "R2 edge idle");
    lvl = 4'b1000; tick(1);
    chk(irq, 1'b1, "R2 polarity edge");

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule